// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls thirteen general-purpose pins from a byte-wide register bus with a 16-bit address. Each pin has two registers. The output-control register sets direction, drive type, pull resistor and output level. The input-control register returns the synchronised pin level and selects which edges of that pin raise an interrupt.

Detected edges are collected in two interrupt groups of unequal width. Group 0 holds pins 0 to 6 and group 1 holds pins 7 to 12. Each group has a write-one-to-clear status register and a mask register. A single interrupt line combines every pending status bit whose mask bit is clear.

The bus is a plain register port with no back-pressure. A write completes on the clock edge at which `reg_wr_en` is high. Read data is combinational from `reg_addr` and is valid in the same cycle, so a bus master never waits. Pad controls are plain level outputs: output value, output enable, drive type, pull enable and pull select.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every output-control and input-control register reads 0 and both status registers read 0. Mask group 0 reads 0x7F and mask group 1 reads 0x3F. `pad_oe` is all zero and `irq_out` is 0.
- R2: Pin p has its output-control register at 0x4E44+p. Its fields are: bit 5 direction (1 = output), bit 4 drive type (1 = push-pull, 0 = open-drain), bit 3 pull enable, bits 2:1 pull select, bit 0 output level. Bits 7:6 read 0.
- R3: After a write, `pad_out[p]` equals the level bit, `pad_push_pull[p]` the drive bit, `pad_pull_en[p]` the pull-enable bit and `pad_pull_sel[2p+1:2p]` the pull-select field.
- R4: `pad_oe[p]` is 1 only when direction is output and either the drive type is push-pull or the output level is 0.
- R5: Pin p has its input-control register at 0x4E51+p. Bit 0 returns the pin level after a two-flop synchroniser. Bits 2:1 hold the edge mode. Bits 7:3 read 0.
- R6: The edge mode selects which edges set the pin's status bit: 00 none, 01 falling, 10 rising, 11 both. The status bit is readable set three clocks after the pad changes.
- R7: Pin p (p < 7) maps to bit p of status 0x4E0B and mask 0x4E19. Pin p (p >= 7) maps to bit p-7 of status 0x4E0C and mask 0x4E1A. Unused upper bits read 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: An edge that arrives in the same cycle as a clear of that bit leaves the bit set.
- R10: A status bit is set whether or not the pin is masked. `irq_out` is the OR of (status AND NOT mask) over both groups.
- R11: Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pad_in | input | 13 | Asynchronous pin levels |
| pad_out | output | 13 | Output level per pin |
| pad_oe | output | 13 | Output enable per pin |
| pad_push_pull | output | 13 | 1 = push-pull, 0 = open-drain |
| pad_pull_en | output | 13 | Pull resistor enable |
| pad_pull_sel | output | 26 | Pull select, two bits per pin |
| irq_out | output | 1 | Combined unmasked interrupt |

## Verification
The bench sweeps every pin through all four edge modes with both edge directions and checks that the status bit lands in the right group and position. A design that inverted the mode encoding, or placed group 1 at the wrong offset, reports a wrong bit. It also sweeps all 64 output-control values on every pin and checks the open-drain enable rule; a design that enabled an open-drain pad while driving high is reported. An edge is timed so that it lands in the same cycle as a clear of its status bit; a design that let the clear win would lose that event. Writes to addresses just outside each range are followed by reads of the neighbouring registers, which catches decode that is off by one.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  parameter int NPINS = 13;
  parameter int G0W   = 7;
  localparam int G1W  = NPINS - G0W;
  localparam logic [15:0] OCTL_BASE = 16'h4E44;
  localparam logic [15:0] ICTL_BASE = 16'h4E51;
  localparam logic [15:0] STAT0_A   = 16'h4E0B;
  localparam logic [15:0] STAT1_A   = 16'h4E0C;
  localparam logic [15:0] MASK0_A   = 16'h4E19;
  localparam logic [15:0] MASK1_A   = 16'h4E1A;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       dir_out;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       level;
  } octl_t;
endpackage

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_edge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_out,
  input  logic       wr_in,
  input  logic [5:0] octl_wdata,
  input  logic [1:0] mode_wdata,
  input  logic       pad_in,
  output logic [5:0] octl_o,
  output logic [1:0] mode_o,
  output logic       level_o,
  output logic       edge_o,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       pad_pp,
  output logic       pad_pull_en,
  output logic [1:0] pad_pull_sel
);
  octl_t      octl_q;
  edge_mode_e mode_q;
  logic       meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      octl_q <= '0;
      mode_q <= EDGE_OFF;
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (wr_out) octl_q <= octl_t'(octl_wdata);
      if (wr_in)  mode_q <= edge_mode_e'(mode_wdata);
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  logic rise, fall;
  assign rise   = sync_q & ~prev_q;
  assign fall   = prev_q & ~sync_q;
  assign edge_o = (mode_q[1] & rise) | (mode_q[0] & fall);

  assign octl_o       = octl_q;
  assign mode_o       = mode_q;
  assign level_o      = sync_q;
  assign pad_out      = octl_q.level;
  assign pad_oe       = octl_q.dir_out & (octl_q.push_pull | ~octl_q.level);
  assign pad_pp       = octl_q.push_pull;
  assign pad_pull_en  = octl_q.pull_en;
  assign pad_pull_sel = octl_q.pull_sel;

  // R2
  octl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> (octl_o == $past(octl_wdata)));

  // R6
  edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (mode_o != EDGE_OFF));
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic         mask_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] status_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~(clr_en ? wdata : '0)) | set_i;
      if (mask_wr) mask_q <= wdata;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign pend_o   = |(status_q & ~mask_q);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_i == '0) |=> ((status_o & $past(wdata)) == '0));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && set_i == '0) |=> $stable(status_o));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [15:0]         reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic [NPINS-1:0]    pad_in,
  output logic [NPINS-1:0]    pad_out,
  output logic [NPINS-1:0]    pad_oe,
  output logic [NPINS-1:0]    pad_push_pull,
  output logic [NPINS-1:0]    pad_pull_en,
  output logic [2*NPINS-1:0]  pad_pull_sel,
  output logic                irq_out
);
  logic [5:0]       octl   [NPINS];
  logic [1:0]       mode   [NPINS];
  logic [NPINS-1:0] level, edges;
  logic             unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[7:6];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_slice u_pin (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_out       (reg_wr_en && reg_addr == OCTL_BASE + 16'(p)),
      .wr_in        (reg_wr_en && reg_addr == ICTL_BASE + 16'(p)),
      .octl_wdata   (reg_wdata[5:0]),
      .mode_wdata   (reg_wdata[2:1]),
      .pad_in       (pad_in[p]),
      .octl_o       (octl[p]),
      .mode_o       (mode[p]),
      .level_o      (level[p]),
      .edge_o       (edges[p]),
      .pad_out      (pad_out[p]),
      .pad_oe       (pad_oe[p]),
      .pad_pp       (pad_push_pull[p]),
      .pad_pull_en  (pad_pull_en[p]),
      .pad_pull_sel (pad_pull_sel[2*p+1:2*p])
    );
  end

  logic [G0W-1:0] stat0, mask0;
  logic [G1W-1:0] stat1, mask1;
  logic           pend0, pend1;

  gpio_irq_group #(.W(G0W)) u_grp0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (edges[G0W-1:0]),
    .clr_en  (reg_wr_en && reg_addr == STAT0_A),
    .mask_wr (reg_wr_en && reg_addr == MASK0_A),
    .wdata   (reg_wdata[G0W-1:0]),
    .status_o(stat0),
    .mask_o  (mask0),
    .pend_o  (pend0)
  );

  gpio_irq_group #(.W(G1W)) u_grp1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (edges[NPINS-1:G0W]),
    .clr_en  (reg_wr_en && reg_addr == STAT1_A),
    .mask_wr (reg_wr_en && reg_addr == MASK1_A),
    .wdata   (reg_wdata[G1W-1:0]),
    .status_o(stat1),
    .mask_o  (mask1),
    .pend_o  (pend1)
  );

  assign irq_out = pend0 | pend1;

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (reg_addr == OCTL_BASE + 16'(p)) reg_rdata = {2'b00, octl[p]};
      if (reg_addr == ICTL_BASE + 16'(p)) reg_rdata = {5'b0, mode[p], level[p]};
    end
    if (reg_addr == STAT0_A) reg_rdata = 8'(stat0);
    if (reg_addr == STAT1_A) reg_rdata = 8'(stat1);
    if (reg_addr == MASK0_A) reg_rdata = 8'(mask0);
    if (reg_addr == MASK1_A) reg_rdata = 8'(mask1);
  end

  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((stat0 & ~mask0) != '0 || (stat1 & ~mask1) != '0));
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
  logic        clk = 0, rst_n = 0, wr = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [12:0] pin = 0, pout, poe, ppp, pen;
  logic [25:0] psel;
  logic        irq;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pad_in(pin), .pad_out(pout),
    .pad_oe(poe), .pad_push_pull(ppp), .pad_pull_en(pen),
    .pad_pull_sel(psel), .irq_out(irq));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #2 d = rdata;
  endtask

  function automatic logic [15:0] st_addr(input int p);
    return (p < 7) ? 16'h4E0B : 16'h4E0C;
  endfunction
  function automatic logic [15:0] mk_addr(input int p);
    return (p < 7) ? 16'h4E19 : 16'h4E1A;
  endfunction
  function automatic logic [7:0] bitof(input int p);
    return 8'(1 << ((p < 7) ? p : p - 7));
  endfunction

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #2;
    check("R1 oe", poe, 0);
    check("R1 irq", irq, 0);
    rreg(16'h4E44, d); check("R1 octl", d, 0);
    rreg(16'h4E5D, d); check("R1 ictl", d, 0);
    rreg(16'h4E0B, d); check("R1 stat0", d, 0);
    rreg(16'h4E19, d); check("R1 mask0", d, 8'h7F);
    rreg(16'h4E1A, d); check("R1 mask1", d, 8'h3F);

    // R2 R3 R4 output control sweep
    for (int p = 0; p < 13; p++) begin
      for (int v = 0; v < 64; v++) begin
        wreg(16'h4E44 + 16'(p), 8'(v) | 8'hC0);
        rreg(16'h4E44 + 16'(p), d);
        check("R2 octl readback", d, v);
        check("R3 pad_out", pout[p], v & 1);
        check("R3 pad_push_pull", ppp[p], (v >> 4) & 1);
        check("R3 pad_pull_en", pen[p], (v >> 3) & 1);
        check("R3 pad_pull_sel", psel[2*p +: 2], (v >> 1) & 3);
        check("R4 pad_oe", poe[p], ((v >> 5) & 1) & (((v >> 4) & 1) | (~v & 1)));
      end
      wreg(16'h4E44 + 16'(p), 8'h00);
    end

    // R5 input control field and level
    wreg(16'h4E51, 8'hFF);
    rreg(16'h4E51, d); check("R5 ictl mode", d, 8'h06);
    wreg(16'h4E51, 8'h00);

    // R6 R7 edge sweep, all masked
    for (int p = 0; p < 13; p++) begin
      for (int m = 0; m < 4; m++) begin
        wreg(16'h4E51 + 16'(p), 8'(m << 1));
        wreg(st_addr(p), 8'hFF);
        @(negedge clk); pin[p] = 1;
        repeat (4) @(negedge clk);
        rreg(16'h4E51 + 16'(p), d); check("R5 level high", d & 1, 1);
        rreg(st_addr(p), d);
        check("R6 R7 rise status", d, (m >> 1) ? bitof(p) : 0);
        check("R10 masked irq", irq, 0);
        wreg(st_addr(p), 8'hFF);
        @(negedge clk); pin[p] = 0;
        repeat (4) @(negedge clk);
        rreg(st_addr(p), d);
        check("R6 R7 fall status", d, (m & 1) ? bitof(p) : 0);
        wreg(st_addr(p), 8'hFF);
        rreg(st_addr(p), d); check("R8 cleared", d, 0);
      end
      wreg(16'h4E51 + 16'(p), 8'h00);
    end

    // R8 write 0 leaves bit, R10 unmask raises irq
    wreg(16'h4E5D, 8'h04);
    @(negedge clk); pin[12] = 1;
    repeat (4) @(negedge clk);
    wreg(16'h4E0C, 8'h00);
    rreg(16'h4E0C, d); check("R8 write zero keeps", d, 8'h20);
    check("R10 irq masked", irq, 0);
    wreg(16'h4E1A, 8'h1F);
    #2 check("R10 irq unmasked", irq, 1);
    wreg(16'h4E0C, 8'h20);
    #2 check("R10 irq after clear", irq, 0);

    // R9 set wins over simultaneous clear
    wreg(16'h4E51, 8'h06);
    @(negedge clk); pin[0] = 1;
    @(negedge clk);
    @(negedge clk); wr = 1; addr = 16'h4E0B; wdata = 8'h01;
    @(negedge clk); wr = 0;
    rreg(16'h4E0B, d); check("R9 set wins", d, 8'h01);
    wreg(16'h4E0B, 8'h01);

    // R11 unmapped addresses
    wreg(16'h4E43, 8'h3F); wreg(16'h4E5E, 8'hFF); wreg(16'h4E0D, 8'hFF);
    wreg(16'h4E1B, 8'h00); wreg(16'h4E18, 8'h00);
    rreg(16'h4E43, d); check("R11 read unmapped", d, 0);
    rreg(16'h4E5E, d); check("R11 read unmapped", d, 0);
    rreg(16'h4E44, d); check("R11 neighbour octl", d, 0);
    rreg(16'h4E5D, d); check("R11 neighbour ictl", d, 8'h05);
    rreg(16'h4E19, d); check("R11 neighbour mask0", d, 8'h7F);
    rreg(16'h4E1A, d); check("R11 neighbour mask1", d, 8'h1F);
    check("R11 pad_oe", poe, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule